// File: doc/BRIEF.md
# Audio Port Frame and Bit Clock Generator

This block produces the frame (left/right) clock and the bit clock for a digital audio serial port. In master mode it divides a selected master clock down to the frame rate. The frame period is one of seven run-time ratios, from 128 to 1152 master-clock cycles, and four of those ratios are not powers of two. In slave mode it drives neither pin and passes the externally supplied clocks through to the port's internal side.

The design is written in the style of an FPGA. Each master-clock source reaches the block as a single-cycle strobe in the system clock domain, so the clocks are never muxed. Selecting a source means selecting a strobe. Software programs the block through a small register write port. A new ratio or source is held back until the current frame ends, so the generated clocks never produce a runt pulse. The bit clock completes 64 periods per frame. The frame clock is low for the first half of each frame and high for the second half.

Top module: `aclk_master_gen`

## Requirements
- R1: Rate register (address 0), field bits [2:0] set master-clock periods per frame: 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1152. In master mode, consecutive frame clock rising edges are that many strobes of the selected source apart.
- R2: Rate code 7 behaves exactly as code 2, giving 256 master-clock periods per frame.
- R3: After reset, the rate code is 2, the source code is 0 and the port is a slave. Both output enables are low and both pin outputs are low. Setting only the master bit then gives a 256-period frame on the main source.
- R4: With the mode bit (address 1, bit 0) clear, `lrclk_oe`, `bclk_oe`, `lrclk_o` and `bclk_o` stay low. `port_lrclk` and `port_bclk` repeat `lrclk_i` and `bclk_i` one clock later.
- R5: In master mode both output enables are high, and the bit clock makes exactly 64 rising edges per frame period.
- R6: The frame clock is high for exactly half of each frame. It changes only in the same cycle as a falling edge of the bit clock.
- R7: Rate register field bits [4:3] select the source: 0 = main strobe, 1 = general-purpose pin strobe while `adc_src_en` is high, 2 and 3 = PLL strobe.
- R8: Source code 1 with `adc_src_en` low uses the main strobe.
- R9: A rate or source write made during a master-mode frame leaves the rest of that frame at the old settings. The new settings take effect from the next frame start (the frame clock falling edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 = rate/source, 1 = mode |
| cfg_wdata | input | 5 | Write data |
| adc_src_en | input | 1 | Enables the general-purpose pin clock source |
| mclk_main_tick | input | 1 | Strobe per period of the main master clock |
| mclk_gpio_tick | input | 1 | Strobe per period of the pin master clock |
| mclk_pll_tick | input | 1 | Strobe per period of the PLL master clock |
| lrclk_i | input | 1 | Frame clock from the pin (slave mode) |
| bclk_i | input | 1 | Bit clock from the pin (slave mode) |
| lrclk_o | output | 1 | Frame clock driven to the pin |
| lrclk_oe | output | 1 | Frame clock pin output enable |
| bclk_o | output | 1 | Bit clock driven to the pin |
| bclk_oe | output | 1 | Bit clock pin output enable |
| port_lrclk | output | 1 | Frame clock seen by the serial port |
| port_bclk | output | 1 | Bit clock seen by the serial port |

## Verification
The assertions assume the following:
- Every source strobe is already synchronous to `clk`.
- `lrclk_i` and `bclk_i` are synchronous and low while reset is asserted.
- The mode bit does not toggle back and forth within a single cycle.

The stimulus meets these conditions. Strobes are generated on the falling edge of `clk` at rates of one in two (main), one in three (pin) and every cycle (PLL). The slave inputs stay low until reset has been released. A mode change is always followed by several idle cycles.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int unsigned RATE_W      = 3;
  localparam int unsigned SRC_W       = 2;
  localparam int unsigned CFG_W       = RATE_W + SRC_W;
  localparam int unsigned MAX_FS_MULT = 1152;

  typedef enum logic [SRC_W-1:0] {
    SRC_MAIN  = 2'b00,
    SRC_PIN   = 2'b01,
    SRC_PLL_A = 2'b10,
    SRC_PLL_B = 2'b11
  } mclk_src_e;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [RATE_W-1:0] rate;
  } rate_cfg_t;

  localparam rate_cfg_t RATE_CFG_RST = '{src: SRC_MAIN, rate: 3'b010};

  // master-clock periods per frame for a rate code
  function automatic int unsigned fs_mult(input logic [RATE_W-1:0] code);
    case (code)
      3'd0:    return 128;
      3'd1:    return 192;
      3'd3:    return 384;
      3'd4:    return 512;
      3'd5:    return 768;
      3'd6:    return 1152;
      default: return 256;
    endcase
  endfunction

endpackage

// File: rtl/aclk_cfg_reg.sv
module aclk_cfg_reg
  import aclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             frame_wrap,
  output logic             master,
  output rate_cfg_t        active
);

  localparam logic RATE_ADDR = 1'b0;
  localparam logic MODE_ADDR = 1'b1;

  rate_cfg_t pend_q, act_q;
  logic      master_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= RATE_CFG_RST;
      act_q    <= RATE_CFG_RST;
      master_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == RATE_ADDR) pend_q <= rate_cfg_t'(wr_data);
      if (wr_en && wr_addr == MODE_ADDR) master_q <= wr_data[0];
      if (!master_q || frame_wrap) act_q <= pend_q;
    end
  end

  assign master = master_q;
  assign active = act_q;

  // R9
  act_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> (!$past(master_q) || $past(frame_wrap)));

endmodule

// File: rtl/aclk_src_sel.sv
module aclk_src_sel
  import aclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src,
  input  logic             pin_src_en,
  input  logic             tick_main,
  input  logic             tick_pin,
  input  logic             tick_pll,
  output logic             tick
);

  logic tick_d, tick_q;

  always_comb begin
    case (mclk_src_e'(src))
      SRC_PIN:   tick_d = pin_src_en ? tick_pin : tick_main;
      SRC_PLL_A,
      SRC_PLL_B: tick_d = tick_pll;
      default:   tick_d = tick_main;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick_d;
  end

  assign tick = tick_q;

  // R7
  tick_origin_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> $past(tick_main || tick_pin || tick_pll));

endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div
  import aclk_pkg::*;
#(
  parameter int unsigned BCLK_PER_FRAME = 64,
  parameter int unsigned DIV_W          = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              frame_wrap,
  output logic              bclk,
  output logic              lrclk
);

  localparam int unsigned BIT_W = $clog2(BCLK_PER_FRAME);

  logic [DIV_W-1:0] per, lo_len, div_q, div_nx;
  logic [BIT_W-1:0] bit_q, bit_nx;
  logic             bclk_q, lrclk_q, div_last;

  assign per      = DIV_W'(fs_mult(rate) / BCLK_PER_FRAME);
  assign lo_len   = per - (per >> 1);
  assign div_last = (div_q == per - 1'b1);

  always_comb begin
    div_nx = div_q;
    bit_nx = bit_q;
    if (tick) begin
      if (div_last) begin
        div_nx = '0;
        bit_nx = bit_q + 1'b1;
      end else begin
        div_nx = div_q + 1'b1;
      end
    end
  end

  assign frame_wrap = run && tick && div_last && (bit_q == {BIT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q   <= '0;
      bit_q   <= '0;
      bclk_q  <= 1'b0;
      lrclk_q <= 1'b0;
    end else begin
      div_q   <= div_nx;
      bit_q   <= bit_nx;
      bclk_q  <= (div_nx >= lo_len);
      lrclk_q <= bit_nx[BIT_W-1];
    end
  end

  assign bclk  = bclk_q;
  assign lrclk = lrclk_q;

  // R1
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    div_q < per);

  // R6
  lr_edge_chk: assert property (@(posedge clk) disable iff (rst || !run)
    !$stable(lrclk_q) |-> $fell(bclk_q));

  // R5
  bit_adv_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bit_q) |-> ($past(tick) || !$past(run)));

endmodule

// File: rtl/aclk_master_gen.sv
module aclk_master_gen
  import aclk_pkg::*;
#(
  parameter int unsigned BCLK_PER_FRAME = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             adc_src_en,
  input  logic             mclk_main_tick,
  input  logic             mclk_gpio_tick,
  input  logic             mclk_pll_tick,
  input  logic             lrclk_i,
  input  logic             bclk_i,
  output logic             lrclk_o,
  output logic             lrclk_oe,
  output logic             bclk_o,
  output logic             bclk_oe,
  output logic             port_lrclk,
  output logic             port_bclk
);

  localparam int unsigned DIV_W = $clog2(MAX_FS_MULT / BCLK_PER_FRAME + 1);

  logic      master_q, frame_wrap, sel_tick, gen_bclk, gen_lrclk;
  rate_cfg_t act_cfg;

  aclk_cfg_reg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_wdata),
    .frame_wrap(frame_wrap),
    .master    (master_q),
    .active    (act_cfg)
  );

  aclk_src_sel u_src (
    .clk       (clk),
    .rst       (rst),
    .src       (act_cfg.src),
    .pin_src_en(adc_src_en),
    .tick_main (mclk_main_tick),
    .tick_pin  (mclk_gpio_tick),
    .tick_pll  (mclk_pll_tick),
    .tick      (sel_tick)
  );

  aclk_frame_div #(
    .BCLK_PER_FRAME(BCLK_PER_FRAME),
    .DIV_W         (DIV_W)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (master_q),
    .tick      (sel_tick),
    .rate      (act_cfg.rate),
    .frame_wrap(frame_wrap),
    .bclk      (gen_bclk),
    .lrclk     (gen_lrclk)
  );

  // pin stage: every output leaves a flop
  always_ff @(posedge clk) begin
    if (rst) begin
      lrclk_o    <= 1'b0;
      bclk_o     <= 1'b0;
      lrclk_oe   <= 1'b0;
      bclk_oe    <= 1'b0;
      port_lrclk <= 1'b0;
      port_bclk  <= 1'b0;
    end else begin
      lrclk_oe   <= master_q;
      bclk_oe    <= master_q;
      lrclk_o    <= master_q && gen_lrclk;
      bclk_o     <= master_q && gen_bclk;
      port_lrclk <= master_q ? gen_lrclk : lrclk_i;
      port_bclk  <= master_q ? gen_bclk  : bclk_i;
    end
  end

  // R4
  released_chk: assert property (@(posedge clk) disable iff (rst)
    !lrclk_oe |-> (!lrclk_o && !bclk_o && !bclk_oe));

  // R4
  slave_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(master_q)) |->
      (port_lrclk == $past(lrclk_i) && port_bclk == $past(bclk_i)));

  // R5
  master_loop_chk: assert property (@(posedge clk) disable iff (rst)
    lrclk_oe |-> (port_lrclk == lrclk_o && port_bclk == bclk_o));

endmodule

// File: tb/aclk_master_gen_tb.sv
module aclk_master_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       adc_src_en = 1'b0;
  logic       tick_main = 1'b0, tick_gpio = 1'b0, tick_pll = 1'b1;
  logic       lrclk_i = 1'b0, bclk_i = 1'b0;
  logic       lrclk_o, lrclk_oe, bclk_o, bclk_oe, port_lrclk, port_bclk;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  aclk_master_gen u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .adc_src_en(adc_src_en), .mclk_main_tick(tick_main), .mclk_gpio_tick(tick_gpio),
    .mclk_pll_tick(tick_pll), .lrclk_i(lrclk_i), .bclk_i(bclk_i),
    .lrclk_o(lrclk_o), .lrclk_oe(lrclk_oe), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .port_lrclk(port_lrclk), .port_bclk(port_bclk)
  );

  // strobes: main every 2 cycles, pin every 3, PLL every cycle
  initial begin
    int c2 = 0;
    int c3 = 0;
    forever begin
      @(negedge clk);
      c2 = (c2 + 1) % 2;
      c3 = (c3 + 1) % 3;
      tick_main = (c2 == 0);
      tick_gpio = (c3 == 0);
    end
  end

  // {rate[3], src[2], adc_en[1], pad[2], expected frame period in clk cycles[16]}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 2'b0, 16'd256},   // R1 128 main
    {3'd1, 2'd0, 1'b0, 2'b0, 16'd384},   // R1 192 main
    {3'd2, 2'd0, 1'b0, 2'b0, 16'd512},   // R1 256 main
    {3'd3, 2'd2, 1'b0, 2'b0, 16'd384},   // R7 384 PLL code 2
    {3'd4, 2'd3, 1'b0, 2'b0, 16'd512},   // R7 512 PLL code 3
    {3'd5, 2'd1, 1'b1, 2'b0, 16'd2304},  // R7 768 pin source
    {3'd6, 2'd0, 1'b0, 2'b0, 16'd2304},  // R1 1152 main
    {3'd7, 2'd0, 1'b0, 2'b0, 16'd512},   // R2 reserved code
    {3'd1, 2'd1, 1'b0, 2'b0, 16'd384},   // R8 pin without enable
    {3'd6, 2'd1, 1'b1, 2'b0, 16'd3456}   // R7 1152 pin source
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [4:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // counts samples from a frame clock rising edge to the next one
  task automatic to_rise(output int n);
    logic pl;
    pl = 1'b1; n = 0;
    forever begin
      @(negedge clk); n++;
      if (!pl && lrclk_o) break;
      pl = lrclk_o;
    end
  endtask

  task automatic measure(output int per, output int hi, output int nb, output bit al);
    logic pl, pb;
    pl = lrclk_o;
    forever begin
      @(negedge clk);
      if (!pl && lrclk_o) break;
      pl = lrclk_o;
    end
    per = 0; hi = 0; nb = 0; al = 1'b1; pl = 1'b1; pb = bclk_o;
    forever begin
      @(negedge clk); per++;
      if (!pb && bclk_o) nb++;
      if (pl != lrclk_o && !(pb && !bclk_o)) al = 1'b0;
      if (pl && !lrclk_o) hi = per;
      if (!pl && lrclk_o) break;
      pl = lrclk_o; pb = bclk_o;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int per, hi, nb, n;
    bit al;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    chk(!lrclk_oe && !bclk_oe, "R3 oe after reset", int'({lrclk_oe, bclk_oe}), 0);
    chk(!lrclk_o && !bclk_o, "R3 pins after reset", int'({lrclk_o, bclk_o}), 0);
    // R3 default rate 256, main source
    wr(1'b1, 5'd1);
    measure(per, hi, nb, al);
    chk(per == 512, "R3 default frame period", per, 512);
    chk(lrclk_oe && bclk_oe, "R5 oe in master", int'({lrclk_oe, bclk_oe}), 3);

    // R9 mid-frame rate change: rest of frame old, next half new
    wr(1'b0, 5'b00_000);
    to_rise(n);
    chk(n + 1 == 384, "R9 transition period", n + 1, 384);
    to_rise(n);
    chk(n == 256, "R9 new period", n, 256);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] rt;
      logic [1:0] sr;
      int exp;
      rt = VEC[i][23:21]; sr = VEC[i][20:19]; exp = int'(VEC[i][15:0]);
      wr(1'b1, 5'd0);
      adc_src_en = VEC[i][18];
      wr(1'b0, {sr, rt});
      repeat (2) @(negedge clk);
      wr(1'b1, 5'd1);
      measure(per, hi, nb, al);
      chk(per == exp, "R1/R2/R7/R8 frame period", per, exp);
      chk(hi == exp / 2, "R6 frame clock high time", hi, exp / 2);
      chk(nb == 64, "R5 bit clocks per frame", nb, 64);
      chk(al, "R6 frame edge on bit clock fall", int'(al), 1);
    end

    // R4 slave: released pins and pass-through
    wr(1'b1, 5'd0);
    repeat (3) @(negedge clk);
    chk(!lrclk_oe && !bclk_oe && !lrclk_o && !bclk_o, "R4 released",
        int'({lrclk_oe, bclk_oe, lrclk_o, bclk_o}), 0);
    lrclk_i = 1'b1; bclk_i = 1'b0;
    @(negedge clk);
    chk(port_lrclk && !port_bclk, "R4 pass-through A", int'({port_lrclk, port_bclk}), 2);
    lrclk_i = 1'b0; bclk_i = 1'b1;
    @(negedge clk);
    chk(!port_lrclk && port_bclk, "R4 pass-through B", int'({port_lrclk, port_bclk}), 1);
    chk(!lrclk_o && !bclk_o, "R4 pins stay low", int'({lrclk_o, bclk_o}), 0);
    summary();
  end

endmodule